// File: doc/BRIEF.md
# Rectangle Fill, Invert and Copy Raster Engine

This block is a small two-dimensional drawing engine for a frame buffer that stores one byte per pixel. Software programs it through a register write port: a clip window, a 16-bit truth-table raster operation, a foreground color, a rectangle corner port and eight copy coordinate registers. It then walks the affected pixels and reads and writes them through a single-port pixel memory interface that uses a request/acknowledge handshake.

A rectangle is filled, or inverted, by writing its top-left corner and then its inclusive bottom-right corner into the corner port, y before x each time. What happens to each pixel depends only on the raster-op register. A copy takes a source rectangle and a destination origin. It launches when the last coordinate register is written, and it picks its row and column walk order so that overlapping regions copy correctly. Two status words report whether a copy is running and whether the engine is busy with any operation.

Top module: `rect_raster_engine`

## Requirements
- R1: After a synchronous active-low reset, both status bits read 0 and `mem_req` is low. The clip window resets to the whole frame (0..FB_W-1, 0..FB_H-1), the raster op resets to 0xCCCC and the foreground color resets to 0.
- R2: Each result bit i is `rop[{fg[i], ~fg[i], src[i], dst[i]}]`, with fg in the MSB of the index. The foreground color is at address 0x05 (bits 7:0) and the raster op is at 0x04. A fill uses a source of 0. So 0xFF00 writes fg, 0x5555 writes ~dst and 0xCCCC writes src.
- R3: The corner port has a y register at 0x06 and an x register at 0x07. The first x write latches the top-left corner from (x, last y). The second x write latches the inclusive bottom-right corner and launches a fill over every pixel in between.
- R4: The copy points are at 0x08..0x0F in the order p0x, p0y, p1x, p1y, p2x, p2y, p3x, p3y. A write to 0x0F launches a copy. The source is p0..p1 inclusive. The destination starts at p2 and has the same size as the source.
- R5: The clip bounds are at 0x00 xmin, 0x01 ymin, 0x02 xmax and 0x03 ymax, all inclusive. A destination pixel outside the window is neither read nor written.
- R6: A copy walks rows bottom-up when p2y > p0y and columns right-to-left when p2x > p0x. Each destination pixel then receives the value its source pixel held before the copy started, even when the two regions overlap.
- R7: Reading address 0x10 returns bit 29 = 1 while a copy is pending or running. Reading 0x11 returns bit 28 = 1 from the cycle after a launching write until the final pixel write is acknowledged. All other bits read 0.
- R8: Every register write made while bit 28 of the engine status would read 1 is ignored. This includes a write landing in the same cycle as the final write acknowledge.
- R9: A fill or copy whose maximum is below its minimum on either axis makes no memory access, and the engine reads idle on the cycle after the write.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`. The pixel address is y*FB_W + x. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (write and status read) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Status read data for reg_addr |
| mem_req | output | 1 | Pixel access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Pixel address y*FB_W + x |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
A register write and the acknowledge of an operation's last pixel write can meet in one clock. The engine is still busy in that cycle, so the write must be dropped. The bench's memory model sees the final destination address being acknowledged and drives a foreground-color write in that same cycle. A following one-pixel fill then has to show the old color. Writes of a new color and of the copy-launch register made in the middle of an operation are judged the same way: the frame memory is compared against a model in which those writes never happened.

// File: rtl/rre_pkg.sv
// Shared definitions for the rectangle raster engine: register map,
// status bit positions and the engine state encoding.
package rre_pkg;

    localparam logic [4:0] A_XMIN      = 5'h00;
    localparam logic [4:0] A_YMIN      = 5'h01;
    localparam logic [4:0] A_XMAX      = 5'h02;
    localparam logic [4:0] A_YMAX      = 5'h03;
    localparam logic [4:0] A_ROP       = 5'h04;
    localparam logic [4:0] A_FG        = 5'h05;
    localparam logic [4:0] A_CORNER_Y  = 5'h06;
    localparam logic [4:0] A_CORNER_X  = 5'h07;
    localparam logic [4:0] A_PT_BASE   = 5'h08;
    localparam logic [4:0] A_PT_LAST   = 5'h0F;
    localparam logic [4:0] A_STAT_BLIT = 5'h10;
    localparam logic [4:0] A_STAT_ENG  = 5'h11;

    localparam int BLIT_BIT = 29;
    localparam int ENG_BIT  = 28;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SCAN,
        ENG_RD_SRC,
        ENG_RD_DST,
        ENG_WR
    } eng_state_e;

endpackage

// File: rtl/rre_regs.sv
// Register file and launch logic. Holds clip bounds, raster op, colour,
// the two corner latches and the eight copy coordinates. Drops writes
// while the engine is busy, emits a one-cycle registered launch for
// non-empty operations, and derives the walk geometry for the engine.
// Assumes coordinates fit in CW bits and the write data is 16 bits.
module rre_regs
    import rre_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FB_W = 32,
    parameter int FB_H = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [4:0]    addr,
    input  logic [15:0]   wdata,
    input  logic          eng_busy,
    output logic [CW-1:0] xmin,
    output logic [CW-1:0] ymin,
    output logic [CW-1:0] xmax,
    output logic [CW-1:0] ymax,
    output logic [15:0]   rop,
    output logic [7:0]    fg,
    output logic          launch,
    output logic          launch_copy,
    output logic [CW-1:0] start_x,
    output logic [CW-1:0] start_y,
    output logic [CW-1:0] end_x,
    output logic [CW-1:0] end_y,
    output logic          rev_x,
    output logic          rev_y,
    output logic [CW-1:0] dlt_x,
    output logic [CW-1:0] dlt_y
);

    logic [CW-1:0] y_pend, ax, ay, bx, by;
    logic          phase;
    logic [CW-1:0] pt [8];
    logic [CW-1:0] wv;
    logic          accept;

    assign wv     = wdata[CW-1:0];
    assign accept = wr && !eng_busy && !launch;

    // Register writes, corner sequencing and launch generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xmin        <= '0;
            ymin        <= '0;
            xmax        <= CW'(FB_W - 1);
            ymax        <= CW'(FB_H - 1);
            rop         <= 16'hCCCC;
            fg          <= '0;
            y_pend      <= '0;
            ax          <= '0;
            ay          <= '0;
            bx          <= '0;
            by          <= '0;
            phase       <= 1'b0;
            launch      <= 1'b0;
            launch_copy <= 1'b0;
            for (int i = 0; i < 8; i++) pt[i] <= '0;
        end else begin
            launch <= 1'b0;
            if (accept) begin
                case (addr)
                    A_XMIN:     xmin   <= wv;
                    A_YMIN:     ymin   <= wv;
                    A_XMAX:     xmax   <= wv;
                    A_YMAX:     ymax   <= wv;
                    A_ROP:      rop    <= wdata;
                    A_FG:       fg     <= wdata[7:0];
                    A_CORNER_Y: y_pend <= wv;
                    A_CORNER_X: begin
                        if (!phase) begin
                            ax    <= wv;
                            ay    <= y_pend;
                            phase <= 1'b1;
                        end else begin
                            bx          <= wv;
                            by          <= y_pend;
                            phase       <= 1'b0;
                            launch      <= (wv >= ax) && (y_pend >= ay);
                            launch_copy <= 1'b0;
                        end
                    end
                    default: begin
                        if (addr[4:3] == A_PT_BASE[4:3]) begin
                            pt[addr[2:0]] <= wv;
                            if (addr == A_PT_LAST) begin
                                launch      <= (pt[2] >= pt[0]) && (pt[3] >= pt[1]);
                                launch_copy <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    logic [CW-1:0] cw_w, cw_h, hi_x, hi_y;
    logic          rx, ry;

    // Walk geometry: fills go forward, copies pick an overlap-safe order.
    always_comb begin
        cw_w = pt[2] - pt[0];
        cw_h = pt[3] - pt[1];
        hi_x = pt[4] + cw_w;
        hi_y = pt[5] + cw_h;
        rx   = pt[4] > pt[0];
        ry   = pt[5] > pt[1];
        if (launch_copy) begin
            rev_x   = rx;
            rev_y   = ry;
            start_x = rx ? hi_x : pt[4];
            end_x   = rx ? pt[4] : hi_x;
            start_y = ry ? hi_y : pt[5];
            end_y   = ry ? pt[5] : hi_y;
            dlt_x   = pt[0] - pt[4];
            dlt_y   = pt[1] - pt[5];
        end else begin
            rev_x   = 1'b0;
            rev_y   = 1'b0;
            start_x = ax;
            end_x   = bx;
            start_y = ay;
            end_y   = by;
            dlt_x   = '0;
            dlt_y   = '0;
        end
    end

endmodule

// File: rtl/rre_walker.sv
// Pixel walker: steps through a rectangle row by row, in either direction
// per axis, and flags the final pixel. Assumes start/end are ordered to
// match the direction bits given at load time.
module rre_walker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] start_x,
    input  logic [CW-1:0] start_y,
    input  logic [CW-1:0] end_x,
    input  logic [CW-1:0] end_y,
    input  logic          rev_x,
    input  logic          rev_y,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          last
);

    logic [CW-1:0] sx_q, ex_q, ey_q;
    logic          rx_q, ry_q;

    assign last = (cur_x == ex_q) && (cur_y == ey_q);

    // Position update on load and on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
            sx_q  <= '0;
            ex_q  <= '0;
            ey_q  <= '0;
            rx_q  <= 1'b0;
            ry_q  <= 1'b0;
        end else if (load) begin
            cur_x <= start_x;
            cur_y <= start_y;
            sx_q  <= start_x;
            ex_q  <= end_x;
            ey_q  <= end_y;
            rx_q  <= rev_x;
            ry_q  <= rev_y;
        end else if (step) begin
            if (cur_x == ex_q) begin
                cur_x <= sx_q;
                cur_y <= ry_q ? cur_y - 1'b1 : cur_y + 1'b1;
            end else begin
                cur_x <= rx_q ? cur_x - 1'b1 : cur_x + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rre_rop.sv
// Bitwise truth-table raster operation. Each result bit selects one bit
// of the 16-bit table using {fg, ~fg, src, dst} of that bit position.
module rre_rop #(
    parameter int PW = 8
) (
    input  logic [15:0]   rop,
    input  logic [PW-1:0] fg,
    input  logic [PW-1:0] src,
    input  logic [PW-1:0] dst,
    output logic [PW-1:0] res
);

    for (genvar i = 0; i < PW; i++) begin : g_bit
        logic [3:0] idx;
        assign idx    = {fg[i], ~fg[i], src[i], dst[i]};
        assign res[i] = rop[idx];
    end

endmodule

// File: rtl/rect_raster_engine.sv
// Top of the rectangle raster engine. Sequences each pixel through an
// optional source read, a destination read and a write, skipping pixels
// outside the clip window. Assumes a pixel memory that holds its request
// inputs steady and answers with a single-cycle acknowledge.
module rect_raster_engine
    import rre_pkg::*;
#(
    parameter int CW     = 16,
    parameter int FB_W   = 32,
    parameter int FB_H   = 32,
    parameter int ADDR_W = $clog2(FB_W * FB_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);

    eng_state_e    state;
    logic          op_copy;
    logic [7:0]    src_val, dst_val;
    logic [CW-1:0] xmin, ymin, xmax, ymax;
    logic [15:0]   rop;
    logic [7:0]    fg_q;
    logic          launch, launch_copy;
    logic [CW-1:0] start_x, start_y, end_x, end_y, dlt_x, dlt_y;
    logic          rev_x, rev_y;
    logic [CW-1:0] cur_x, cur_y;
    logic          last, w_step, in_clip;
    logic          eng_busy, busy_all, copy_all;
    logic [CW-1:0] src_x, src_y;
    logic [ADDR_W-1:0] dst_addr, src_addr;

    assign eng_busy = (state != ENG_IDLE);

    rre_regs #(.CW(CW), .FB_W(FB_W), .FB_H(FB_H)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .eng_busy(eng_busy),
        .xmin(xmin), .ymin(ymin), .xmax(xmax), .ymax(ymax),
        .rop(rop), .fg(fg_q), .launch(launch), .launch_copy(launch_copy),
        .start_x(start_x), .start_y(start_y), .end_x(end_x), .end_y(end_y),
        .rev_x(rev_x), .rev_y(rev_y), .dlt_x(dlt_x), .dlt_y(dlt_y)
    );

    rre_walker #(.CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(launch), .step(w_step),
        .start_x(start_x), .start_y(start_y), .end_x(end_x), .end_y(end_y),
        .rev_x(rev_x), .rev_y(rev_y),
        .cur_x(cur_x), .cur_y(cur_y), .last(last)
    );

    rre_rop #(.PW(8)) u_rop (
        .rop(rop), .fg(fg_q), .src(src_val), .dst(dst_val), .res(mem_wdata)
    );

    assign in_clip  = (cur_x >= xmin) && (cur_x <= xmax) &&
                      (cur_y >= ymin) && (cur_y <= ymax);
    assign src_x    = cur_x + dlt_x;
    assign src_y    = cur_y + dlt_y;
    assign dst_addr = ADDR_W'(ADDR_W'(cur_y) * ADDR_W'(FB_W) + ADDR_W'(cur_x));
    assign src_addr = ADDR_W'(ADDR_W'(src_y) * ADDR_W'(FB_W) + ADDR_W'(src_x));

    // Walker advances after a skipped pixel or an acknowledged write.
    assign w_step = !last && (((state == ENG_SCAN) && !in_clip) ||
                              ((state == ENG_WR) && mem_ack));

    // Memory request decode from the engine state.
    always_comb begin
        mem_req  = (state == ENG_RD_SRC) || (state == ENG_RD_DST) || (state == ENG_WR);
        mem_we   = (state == ENG_WR);
        mem_addr = (state == ENG_RD_SRC) ? src_addr : dst_addr;
    end

    // Per-pixel sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            op_copy <= 1'b0;
            src_val <= '0;
            dst_val <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (launch) begin
                    state   <= ENG_SCAN;
                    op_copy <= launch_copy;
                    src_val <= '0;
                end
                ENG_SCAN: begin
                    if (in_clip)   state <= op_copy ? ENG_RD_SRC : ENG_RD_DST;
                    else if (last) state <= ENG_IDLE;
                end
                ENG_RD_SRC: if (mem_ack) begin
                    src_val <= mem_rdata;
                    state   <= ENG_RD_DST;
                end
                ENG_RD_DST: if (mem_ack) begin
                    dst_val <= mem_rdata;
                    state   <= ENG_WR;
                end
                ENG_WR: if (mem_ack) state <= last ? ENG_IDLE : ENG_SCAN;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy_all = eng_busy || launch;
    assign copy_all = (eng_busy && op_copy) || (launch && launch_copy);

    // Status read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT_BLIT) reg_rdata[BLIT_BIT] = copy_all;
        if (reg_addr == A_STAT_ENG)  reg_rdata[ENG_BIT]  = busy_all;
    end

endmodule

// File: rtl/rre_chk.sv
// Property checker for the rectangle raster engine, bound to the top.
module rre_chk #(
    parameter int CW     = 16,
    parameter int FB_W   = 32,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              reg_wr,
    input logic              eng_busy,
    input logic              launch,
    input logic [7:0]        fg_q,
    input logic [CW-1:0]     xmin,
    input logic [CW-1:0]     xmax,
    input logic [CW-1:0]     ymin,
    input logic [CW-1:0]     ymax
);

    logic [CW-1:0] wx, wy;
    assign wx = CW'(mem_addr % ADDR_W'(FB_W));
    assign wy = CW'(mem_addr / ADDR_W'(FB_W));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R5
    clip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (wx >= xmin) && (wx <= xmax) && (wy >= ymin) && (wy <= ymax));

    // R8
    busy_fg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy && reg_wr |=> $stable(fg_q));

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> eng_busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mem_req);

endmodule

bind rect_raster_engine rre_chk #(.CW(CW), .FB_W(FB_W), .ADDR_W(ADDR_W)) u_rre_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_wr(reg_wr), .eng_busy(eng_busy), .launch(launch), .fg_q(fg_q),
    .xmin(xmin), .xmax(xmax), .ymin(ymin), .ymax(ymax)
);

// File: tb/rect_raster_engine_bench.sv
module rect_raster_engine_bench;

    localparam int FW = 32;
    localparam int FH = 32;
    localparam int N  = FW * FH;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_wr = 1'b0, col_wr = 1'b0;
    logic [4:0]  drv_addr = 5'h11, col_addr = 5'h05;
    logic [15:0] drv_wdata = '0, col_wdata = '0;
    logic reg_wr;
    logic [4:0] reg_addr;
    logic [15:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata = '0;

    logic [7:0] fb   [N];
    logic [7:0] snap [N];
    logic [7:0] expv [N];

    int checks = 0, errors = 0, cycles = 0;
    int wait_cnt = 0;
    logic ack_prev = 1'b0;
    int hit_addr = -1;
    logic [15:0] hit_data = '0;
    int req_seen = 0;

    int cxmin = 0, cymin = 0, cxmax = FW - 1, cymax = FH - 1;
    logic [15:0] crop = 16'hCCCC;
    logic [7:0] cfg = 8'h00;

    assign reg_wr    = drv_wr | col_wr;
    assign reg_addr  = col_wr ? col_addr : drv_addr;
    assign reg_wdata = col_wr ? col_wdata : drv_wdata;

    always #5 clk = ~clk;

    rect_raster_engine #(.CW(16), .FB_W(FW), .FB_H(FH)) u_rect_raster_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Pixel memory model with random latency and a collision hook.
    always @(negedge clk) begin
        mem_ack = 1'b0;
        col_wr  = 1'b0;
        if (rst_n && mem_req) req_seen = req_seen + 1;
        if (rst_n && mem_req && !ack_prev) begin
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    fb[mem_addr] = mem_wdata;
                    if (int'(mem_addr) == hit_addr) begin
                        col_wr = 1'b1;
                        col_addr = 5'h05;
                        col_wdata = hit_data;
                        hit_addr = -1;
                    end
                end else begin
                    mem_rdata = fb[mem_addr];
                end
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt = wait_cnt - 1;
            end
        end
        ack_prev = mem_ack;
    end

    function automatic logic [7:0] ref_rop(input logic [15:0] r, input logic [7:0] f,
                                           input logic [7:0] s, input logic [7:0] d);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = r[{f[i], ~f[i], s[i], d[i]}];
        return o;
    endfunction

    function automatic logic inclip(input int x, input int y);
        return (x >= cxmin) && (x <= cxmax) && (y >= cymin) && (y <= cymax);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        drv_wr = 1'b1; drv_addr = a; drv_wdata = d;
        @(negedge clk);
        drv_wr = 1'b0; drv_addr = 5'h11;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (reg_rdata[28] && n < 20000);
    endtask

    task automatic take_snap();
        for (int i = 0; i < N; i++) begin snap[i] = fb[i]; expv[i] = fb[i]; end
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int i = 0; i < N; i++) if (bad < 0 && fb[i] !== expv[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, fb[bad], expv[bad]);
    endtask

    task automatic set_clip(input int x0, input int y0, input int x1, input int y1);
        cxmin = x0; cymin = y0; cxmax = x1; cymax = y1;
        wr_reg(5'h00, 16'(x0)); wr_reg(5'h01, 16'(y0));
        wr_reg(5'h02, 16'(x1)); wr_reg(5'h03, 16'(y1));
    endtask

    task automatic set_op(input logic [15:0] r, input logic [7:0] f);
        crop = r; cfg = f;
        wr_reg(5'h04, r); wr_reg(5'h05, {8'h00, f});
    endtask

    task automatic launch_fill(input int x0, input int y0, input int x1, input int y1);
        take_snap();
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                if (inclip(x, y)) expv[y*FW+x] = ref_rop(crop, cfg, 8'h00, snap[y*FW+x]);
        wr_reg(5'h06, 16'(y0)); wr_reg(5'h07, 16'(x0));
        wr_reg(5'h06, 16'(y1)); wr_reg(5'h07, 16'(x1));
    endtask

    task automatic launch_copy(input int sx0, input int sy0, input int sx1, input int sy1,
                               input int dx, input int dy);
        take_snap();
        for (int y = 0; y <= sy1 - sy0; y++)
            for (int x = 0; x <= sx1 - sx0; x++)
                if (inclip(dx + x, dy + y))
                    expv[(dy+y)*FW+dx+x] = ref_rop(crop, cfg, snap[(sy0+y)*FW+sx0+x],
                                                   snap[(dy+y)*FW+dx+x]);
        wr_reg(5'h08, 16'(sx0)); wr_reg(5'h09, 16'(sy0));
        wr_reg(5'h0A, 16'(sx1)); wr_reg(5'h0B, 16'(sy1));
        wr_reg(5'h0C, 16'(dx));  wr_reg(5'h0D, 16'(dy));
        wr_reg(5'h0E, 16'(dx + sx1 - sx0)); wr_reg(5'h0F, 16'(dy + sy1 - sy0));
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < N; i++) fb[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(reg_rdata[28] == 1'b0 && mem_req == 1'b0, "R1 idle after reset", reg_rdata[28], 0);
        drv_addr = 5'h10; #1;
        check(reg_rdata == 32'h0, "R1 blit status after reset", reg_rdata, 0);
        drv_addr = 5'h11;
        @(negedge clk); rst_n = 1'b1;

        // R3 R2: solid fill with reset clip (whole frame)
        set_op(16'hFF00, 8'hA5);
        launch_fill(3, 4, 9, 7);
        @(negedge clk); #1;
        check(reg_rdata[28] == 1'b1, "R7 engine bit during fill", reg_rdata[28], 1);
        drv_addr = 5'h10; #1;
        check(reg_rdata[29] == 1'b0, "R7 blit bit clear during fill", reg_rdata[29], 0);
        drv_addr = 5'h11;
        wait_idle(); cmp_mem("R3 fill");

        // R2: invert
        set_op(16'h5555, 8'h00);
        launch_fill(0, 0, 5, 2);
        wait_idle(); cmp_mem("R2 invert");

        // R5: partial clip
        set_clip(4, 5, 10, 8);
        set_op(16'hFF00, 8'h3C);
        launch_fill(0, 0, 15, 15);
        wait_idle(); cmp_mem("R5 clipped fill");
        set_clip(0, 0, FW-1, FH-1);

        // R4 R7: plain copy
        set_op(16'hCCCC, 8'h00);
        launch_copy(1, 1, 6, 4, 20, 20);
        @(negedge clk); #1;
        drv_addr = 5'h10; #1;
        check(reg_rdata[29] == 1'b1, "R7 blit bit during copy", reg_rdata[29], 1);
        drv_addr = 5'h11;
        wait_idle(); cmp_mem("R4 copy");
        drv_addr = 5'h10; #1;
        check(reg_rdata[29] == 1'b0, "R7 blit bit clear after copy", reg_rdata[29], 0);
        drv_addr = 5'h11;

        // R6: overlapping copies in both directions
        launch_copy(8, 8, 15, 14, 9, 10);
        wait_idle(); cmp_mem("R6 overlap down-right");
        launch_copy(8, 8, 15, 14, 6, 7);
        wait_idle(); cmp_mem("R6 overlap up-left");

        // R9: empty fill and empty copy
        take_snap();
        req_seen = 0;
        wr_reg(5'h06, 16'd10); wr_reg(5'h07, 16'd10);
        wr_reg(5'h06, 16'd12); wr_reg(5'h07, 16'd5);
        #1;
        check(reg_rdata[28] == 1'b0, "R9 empty fill idle", reg_rdata[28], 0);
        wr_reg(5'h08, 16'd9); wr_reg(5'h0A, 16'd3); wr_reg(5'h0F, 16'd0);
        #1;
        check(reg_rdata[28] == 1'b0 && req_seen == 0, "R9 empty copy no access", req_seen, 0);
        cmp_mem("R9 memory untouched");

        // R8: writes during an operation are dropped
        set_op(16'hFF00, 8'h11);
        launch_fill(0, 20, 7, 27);
        wr_reg(5'h05, 16'h00EE);
        wr_reg(5'h0F, 16'd3);
        wait_idle(); cmp_mem("R8 busy writes ignored");
        launch_fill(30, 30, 30, 30);
        wait_idle(); cmp_mem("R8 colour kept after busy write");

        // R8: write colliding with final write acknowledge
        set_op(16'hFF00, 8'h3C);
        hit_addr = 4 * FW + 4; hit_data = 16'h0077;
        launch_fill(2, 2, 4, 4);
        wait_idle(); cmp_mem("R8 collision fill");
        launch_fill(10, 10, 10, 10);
        wait_idle(); cmp_mem("R8 collision write ignored");

        // R2 R4 R5 R6: constrained random mix
        for (int it = 0; it < 24; it++) begin
            int k, w, h, x0, y0, x1, y1;
            logic [15:0] r;
            x0 = $urandom % 12; y0 = $urandom % 12;
            set_clip(x0, y0, x0 + $urandom % 20, y0 + $urandom % 20);
            k = $urandom % 3;
            r = (k == 0) ? 16'hFF00 : (k == 1) ? 16'h5555 : 16'hCCCC;
            if ($urandom % 4 == 0) r = 16'($urandom);
            set_op(r, 8'($urandom));
            w = $urandom % 7; h = $urandom % 7;
            x0 = $urandom % (FW - w); y0 = $urandom % (FH - h);
            if (k == 2) begin
                x1 = $urandom % (FW - w); y1 = $urandom % (FH - h);
                launch_copy(x0, y0, x0 + w, y0 + h, x1, y1);
                wait_idle(); cmp_mem("R6 random copy");
            end else begin
                launch_fill(x0, y0, x0 + w, y0 + h);
                wait_idle(); cmp_mem("R2 random fill");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule